// File: doc/BRIEF.md
# Source Operand Addressing Unit

This unit resolves the source operand of a 16-bit two-operand instruction once the instruction word has been decoded. A one-cycle start pulse delivers the source register number, the 2-bit addressing mode and the byte/word flag. The unit then runs the bus traffic the mode needs: it fetches extension words at the program counter, reads operand data from memory and writes back auto-incremented registers. It returns the operand with a one-cycle done pulse.

Registers 0, 2 and 3 are special. Register 3 in any mode, and register 2 in the two indirect modes, produce hardwired constants and touch no memory. Register 0 turns the indexed mode into PC-relative addressing and the auto-increment mode into an immediate. Register 2 in indexed mode gives absolute addressing.

Interface timing: the register-file read port is combinational, and its address is valid in the cycle that start is high. Memory returns the aligned word that holds the requested address in the cycle after `mem_req_o`. Each `pc_inc_o` cycle makes the PC owner add 2 at the next clock edge.

Top module: `src_operand_unit`

## Requirements
- R1: Mode 00 on a register other than 3 returns that register's value with `done_o` high in the first cycle after the start cycle, with no memory request.
- R2: Mode 10 on a register other than 2 or 3 makes one memory request at the register's value, and `done_o` rises in the third cycle after start. No request, register write or PC increment happens while the unit is idle.
- R3: Mode 11 on a register other than 0, 2 or 3 behaves like R2. In the same cycle as its memory request, it writes the register back increased by 2 for a word operation or by 1 for a byte operation.
- R4: Mode 01 on a general register fetches an index word at the PC and requests a PC advance of 2 in that cycle. It then reads the operand at index plus register. That is two requests, and `done_o` rises in the fifth cycle after start.
- R5: Mode 01 with register 0 uses, as the base, the PC value at which the index word was fetched.
- R6: Mode 01 with register 2 uses the fetched word itself as the operand address (zero base).
- R7: Mode 11 with register 0 returns the word at the PC as the operand and advances the PC by 2. That is one request, and `done_o` rises in the third cycle after start.
- R8: Register 3 gives 0, 1, 2 and 0xFFFF for modes 00, 01, 10 and 11. Register 2 gives 4 for mode 10 and 8 for mode 11. In all these cases `done_o` rises in the first cycle after start, with no memory request, register write or PC change.
- R9: In byte mode the operand is zero-extended from one byte. For a memory operand, address bit 0 = 1 selects bits 15:8 of the returned word and bit 0 = 0 selects bits 7:0. Register values, constants and immediates take bits 7:0.
- R10: `done_o` is high for exactly one cycle per operation. A start pulse that arrives while an operation is in progress is ignored.
- R11: While `rst_ni` is low, `done_o`, `mem_req_o`, `rf_we_o` and `pc_inc_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_i | input | 2 | Source addressing mode |
| reg_i | input | 4 | Source register number |
| byte_i | input | 1 | 1 = byte operation, 0 = word |
| rf_raddr_o | output | 4 | Register-file read address |
| rf_rdata_i | input | 16 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable (auto-increment) |
| rf_waddr_o | output | 4 | Register-file write address |
| rf_wdata_o | output | 16 | Register-file write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, one cycle after request |
| pc_i | input | 16 | Current program counter |
| pc_inc_o | output | 1 | Request to advance the PC by 2 |
| done_o | output | 1 | Operand valid, one-cycle pulse |
| operand_o | output | 16 | Resolved source operand |

## Verification
A vector table covers every mode on ordinary registers, each special register and mode pair, and byte and word widths. For each entry the bench checks the operand, the cycle in which done rises, the number of memory requests, the PC after the operation and the source register after the operation. Together these separate a missed constant decode from a real memory access, a PC-relative base from an indexed base, and an auto-increment step of 1 from one of 2. The byte cases use both an odd and an even operand address, so a wrong lane choice shows. Directed tests hold start high across an operation to show extra pulses are dropped, and check the outputs while reset is held.

// File: rtl/src_opnd_pkg.sv
package src_opnd_pkg;
  typedef enum logic [2:0] {
    K_REG, K_CONST, K_IND, K_AUTO, K_IMM, K_IDX, K_SYM, K_ABS
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WORD, S_WORD_RX, S_DATA, S_DATA_RX, S_DONE
  } state_e;
endpackage

// File: rtl/src_opnd_decode.sv
module src_opnd_decode
  import src_opnd_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RAW    = 4,
  parameter int PC_REG = 0,
  parameter int SR_REG = 2,
  parameter int CG_REG = 3
) (
  input  logic [1:0]     mode_i,
  input  logic [RAW-1:0] reg_i,
  output kind_e          kind_o,
  output logic [DW-1:0]  cval_o
);
  logic is_pc, is_sr, is_cg;
  assign is_pc = (reg_i == RAW'(PC_REG));
  assign is_sr = (reg_i == RAW'(SR_REG));
  assign is_cg = (reg_i == RAW'(CG_REG));

  always_comb begin
    kind_o = K_REG;
    cval_o = '0;
    if (is_cg) begin
      kind_o = K_CONST;
      case (mode_i)
        2'b00:   cval_o = '0;
        2'b01:   cval_o = DW'(1);
        2'b10:   cval_o = DW'(2);
        default: cval_o = '1;
      endcase
    end else if (is_sr && mode_i[1]) begin
      kind_o = K_CONST;
      cval_o = mode_i[0] ? DW'(8) : DW'(4);
    end else begin
      case (mode_i)
        2'b00:   kind_o = K_REG;
        2'b01:   kind_o = is_pc ? K_SYM : (is_sr ? K_ABS : K_IDX);
        2'b10:   kind_o = K_IND;
        default: kind_o = is_pc ? K_IMM : K_AUTO;
      endcase
    end
  end
endmodule

// File: rtl/src_opnd_lane.sv
module src_opnd_lane #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] word_i,
  input  logic [DW-1:0] addr_i,
  input  logic          byte_i,
  output logic [DW-1:0] data_o
);
  localparam int NB = DW / 8;
  localparam int LW = (NB > 1) ? $clog2(NB) : 1;

  logic [7:0] lanes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = word_i[8*g +: 8];
  end

  always_comb begin
    if (byte_i) data_o = DW'(lanes[addr_i[LW-1:0]]);
    else        data_o = word_i;
  end
endmodule

// File: rtl/src_opnd_seq.sv
module src_opnd_seq
  import src_opnd_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RAW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  kind_e          kind_i,
  input  logic [DW-1:0]  cval_i,
  input  logic [RAW-1:0] reg_i,
  input  logic           byte_i,
  output logic [RAW-1:0] rf_raddr_o,
  input  logic [DW-1:0]  rf_rdata_i,
  output logic           rf_we_o,
  output logic [RAW-1:0] rf_waddr_o,
  output logic [DW-1:0]  rf_wdata_o,
  output logic           mem_req_o,
  output logic [DW-1:0]  mem_addr_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic [DW-1:0]  pc_i,
  output logic           pc_inc_o,
  output logic [DW-1:0]  lane_word_o,
  output logic [DW-1:0]  lane_addr_o,
  output logic           lane_byte_o,
  input  logic [DW-1:0]  lane_data_i,
  output logic           done_o,
  output logic           busy_o,
  output logic [DW-1:0]  operand_o
);
  localparam int WSTEP = DW / 8;

  state_e         state;
  kind_e          kind_q;
  logic [RAW-1:0] reg_q;
  logic           byte_q;
  logic [DW-1:0]  base_q, addr_q, opnd_q;
  logic           idle;

  assign idle = (state == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= S_IDLE;
      kind_q <= K_REG;
      reg_q  <= '0;
      byte_q <= 1'b0;
      base_q <= '0;
      addr_q <= '0;
      opnd_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          reg_q  <= reg_i;
          kind_q <= kind_i;
          byte_q <= byte_i;
          base_q <= (kind_i == K_ABS) ? '0 : rf_rdata_i;
          addr_q <= rf_rdata_i;
          case (kind_i)
            K_CONST, K_REG: begin
              opnd_q <= lane_data_i;
              state  <= S_DONE;
            end
            K_IND, K_AUTO: state <= S_DATA;
            default:       state <= S_WORD;
          endcase
        end
        S_WORD: begin
          // PC-relative base is the address of the extension word
          if (kind_q == K_SYM) base_q <= pc_i;
          state <= S_WORD_RX;
        end
        S_WORD_RX: begin
          if (kind_q == K_IMM) begin
            opnd_q <= lane_data_i;
            state  <= S_DONE;
          end else begin
            addr_q <= mem_rdata_i + base_q;
            state  <= S_DATA;
          end
        end
        S_DATA:    state <= S_DATA_RX;
        S_DATA_RX: begin
          opnd_q <= lane_data_i;
          state  <= S_DONE;
        end
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign rf_raddr_o  = idle ? reg_i : reg_q;
  assign mem_req_o   = (state == S_WORD) || (state == S_DATA);
  assign mem_addr_o  = (state == S_WORD) ? pc_i : addr_q;
  assign pc_inc_o    = (state == S_WORD);
  assign rf_we_o     = (state == S_DATA) && (kind_q == K_AUTO);
  assign rf_waddr_o  = reg_q;
  assign rf_wdata_o  = addr_q + (byte_q ? DW'(1) : DW'(WSTEP));
  assign lane_word_o = idle ? ((kind_i == K_CONST) ? cval_i : rf_rdata_i) : mem_rdata_i;
  assign lane_addr_o = (idle || kind_q == K_IMM) ? '0 : addr_q;
  assign lane_byte_o = idle ? byte_i : byte_q;
  assign done_o      = (state == S_DONE);
  assign busy_o      = !idle;
  assign operand_o   = opnd_q;
endmodule

// File: rtl/src_operand_unit.sv
module src_operand_unit
  import src_opnd_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RAW    = 4,
  parameter int PC_REG = 0,
  parameter int SR_REG = 2,
  parameter int CG_REG = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [1:0]     mode_i,
  input  logic [RAW-1:0] reg_i,
  input  logic           byte_i,
  output logic [RAW-1:0] rf_raddr_o,
  input  logic [DW-1:0]  rf_rdata_i,
  output logic           rf_we_o,
  output logic [RAW-1:0] rf_waddr_o,
  output logic [DW-1:0]  rf_wdata_o,
  output logic           mem_req_o,
  output logic [DW-1:0]  mem_addr_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic [DW-1:0]  pc_i,
  output logic           pc_inc_o,
  output logic           done_o,
  output logic [DW-1:0]  operand_o
);
  kind_e         kind;
  logic [DW-1:0] cval;
  logic [DW-1:0] lane_word, lane_addr, lane_data;
  logic          lane_byte;
  logic          busy;

  src_opnd_decode #(
    .DW(DW), .RAW(RAW), .PC_REG(PC_REG), .SR_REG(SR_REG), .CG_REG(CG_REG)
  ) u_decode (
    .mode_i (mode_i),
    .reg_i  (reg_i),
    .kind_o (kind),
    .cval_o (cval)
  );

  src_opnd_lane #(.DW(DW)) u_lane (
    .word_i (lane_word),
    .addr_i (lane_addr),
    .byte_i (lane_byte),
    .data_o (lane_data)
  );

  src_opnd_seq #(.DW(DW), .RAW(RAW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .kind_i      (kind),
    .cval_i      (cval),
    .reg_i       (reg_i),
    .byte_i      (byte_i),
    .rf_raddr_o  (rf_raddr_o),
    .rf_rdata_i  (rf_rdata_i),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .pc_i        (pc_i),
    .pc_inc_o    (pc_inc_o),
    .lane_word_o (lane_word),
    .lane_addr_o (lane_addr),
    .lane_byte_o (lane_byte),
    .lane_data_i (lane_data),
    .done_o      (done_o),
    .busy_o      (busy),
    .operand_o   (operand_o)
  );
endmodule

// File: rtl/src_operand_unit_chk.sv
module src_operand_unit_chk #(
  parameter int DW  = 16,
  parameter int RAW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [1:0]     mode_i,
  input logic [RAW-1:0] reg_i,
  input logic           busy_i,
  input logic           done_o,
  input logic           mem_req_o,
  input logic [DW-1:0]  mem_addr_o,
  input logic [DW-1:0]  pc_i,
  input logic           pc_inc_o,
  input logic           rf_we_o
);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  const_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && reg_i == RAW'(3)) |=> (done_o && !mem_req_o && !rf_we_o));

  // R1
  reg_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && mode_i == 2'b00 && reg_i != RAW'(3)) |=> done_o);

  // R4
  ext_at_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |-> (mem_req_o && mem_addr_o == pc_i));

  // R3
  wb_with_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (mem_req_o && !pc_inc_o));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !(mem_req_o || rf_we_o || pc_inc_o));

  // R11
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !(done_o || mem_req_o || rf_we_o || pc_inc_o));
endmodule

bind src_operand_unit src_operand_unit_chk #(.DW(DW), .RAW(RAW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .reg_i      (reg_i),
  .busy_i     (busy),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .pc_i       (pc_i),
  .pc_inc_o   (pc_inc_o),
  .rf_we_o    (rf_we_o)
);

// File: tb/sim_src_operand_unit.sv
module sim_src_operand_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [3:0]  reg_i = '0;
  logic        byte_i = 1'b0;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, operand;
  logic [15:0] mem_rdata = '0;
  logic [15:0] pc = 16'h0040;
  logic        rf_we, mem_req, pc_inc, done;

  logic [15:0] rf [16];
  logic [15:0] mem [256];

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (pc_inc) pc <= pc + 16'd2;
    if (mem_req) mem_rdata <= mem[mem_addr[8:1]];
  end

  src_operand_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .reg_i(reg_i), .byte_i(byte_i), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .pc_i(pc), .pc_inc_o(pc_inc), .done_o(done), .operand_o(operand)
  );

  // {mode, reg, byte, requests, latency}
  localparam logic [11:0] VEC [21] = '{
    {2'd0, 4'd4, 1'b0, 2'd0, 3'd1}, {2'd0, 4'd5, 1'b1, 2'd0, 3'd1},
    {2'd0, 4'd2, 1'b0, 2'd0, 3'd1}, {2'd2, 4'd4, 1'b0, 2'd1, 3'd3},
    {2'd2, 4'd5, 1'b1, 2'd1, 3'd3}, {2'd2, 4'd6, 1'b1, 2'd1, 3'd3},
    {2'd3, 4'd6, 1'b0, 2'd1, 3'd3}, {2'd3, 4'd7, 1'b1, 2'd1, 3'd3},
    {2'd1, 4'd8, 1'b0, 2'd2, 3'd5}, {2'd1, 4'd9, 1'b1, 2'd2, 3'd5},
    {2'd1, 4'd0, 1'b0, 2'd2, 3'd5}, {2'd1, 4'd2, 1'b1, 2'd2, 3'd5},
    {2'd3, 4'd0, 1'b0, 2'd1, 3'd3}, {2'd3, 4'd0, 1'b1, 2'd1, 3'd3},
    {2'd0, 4'd3, 1'b0, 2'd0, 3'd1}, {2'd1, 4'd3, 1'b0, 2'd0, 3'd1},
    {2'd2, 4'd3, 1'b0, 2'd0, 3'd1}, {2'd3, 4'd3, 1'b0, 2'd0, 3'd1},
    {2'd3, 4'd3, 1'b1, 2'd0, 3'd1}, {2'd2, 4'd2, 1'b0, 2'd0, 3'd1},
    {2'd3, 4'd2, 1'b0, 2'd0, 3'd1}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input logic [15:0] w, input logic a0, input logic b);
    if (!b) return w;
    return a0 ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic run_case(input logic [1:0] m, input logic [3:0] r, input logic b,
                          input int exp_req, input int exp_lat);
    logic [15:0] e_op, e_pc, e_rf, addr, base;
    string tag;
    int n, q;
    e_pc = pc;
    e_rf = rf[r];
    if (r == 4'd3 || (r == 4'd2 && m[1])) begin
      tag = "R8";
      if (r == 4'd3) e_op = (m == 2'd0) ? 16'h0 : (m == 2'd1) ? 16'h1 :
                            (m == 2'd2) ? 16'h2 : 16'hFFFF;
      else e_op = m[0] ? 16'h8 : 16'h4;
      e_op = pick(e_op, 1'b0, b);
    end else if (m == 2'd0) begin
      tag = "R1";
      e_op = pick(rf[r], 1'b0, b);
    end else if (m == 2'd1) begin
      tag = (r == 4'd0) ? "R5" : (r == 4'd2) ? "R6" : "R4";
      base = (r == 4'd0) ? pc : (r == 4'd2) ? 16'h0 : rf[r];
      addr = mem[pc[8:1]] + base;
      e_pc = pc + 16'd2;
      e_op = pick(mem[addr[8:1]], addr[0], b);
    end else if (m == 2'd3 && r == 4'd0) begin
      tag = "R7";
      e_op = pick(mem[pc[8:1]], 1'b0, b);
      e_pc = pc + 16'd2;
    end else begin
      tag = (m == 2'd3) ? "R3" : "R2";
      addr = rf[r];
      e_op = pick(mem[addr[8:1]], addr[0], b);
      if (m == 2'd3) e_rf = rf[r] + (b ? 16'd1 : 16'd2);
    end
    @(negedge clk);
    mode_i = m; reg_i = r; byte_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 1; q = 0;
    while (!done && n < 20) begin
      if (mem_req) q++;
      @(negedge clk);
      n++;
    end
    chk(operand == e_op, b ? "R9" : tag, "operand", operand, e_op);
    chk(n == exp_lat, tag, "latency", 16'(n), 16'(exp_lat));
    chk(q == exp_req, tag, "requests", 16'(q), 16'(exp_req));
    chk(pc == e_pc, tag, "pc", pc, e_pc);
    chk(rf[r] == e_rf, tag, "register", rf[r], e_rf);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 16'h0090 + 16'(i) * 16'h000A;
    rf[5] = 16'h00C3;
    rf[7] = 16'h0101;
    for (int i = 0; i < 256; i++) mem[i] = 16'h1357 ^ (16'(i) * 16'h0203);

    // R11: outputs quiet while reset is held
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !rf_we && !pc_inc, "R11", "reset outputs",
        {12'h0, done, mem_req, rf_we, pc_inc}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req, "R11", "after release", {14'h0, done, mem_req}, 16'h0);

    for (int k = 0; k < 21; k++)
      run_case(VEC[k][11:10], VEC[k][9:6], VEC[k][5], int'(VEC[k][4:3]), int'(VEC[k][2:0]));

    // R10: start held high across an indirect read; extra pulses ignored
    begin
      int n, q, d;
      logic [15:0] e_op;
      e_op = mem[rf[4][8:1]];
      @(negedge clk);
      mode_i = 2'd2; reg_i = 4'd4; byte_i = 1'b0; start_i = 1'b1;
      n = 0; q = 0;
      do begin
        if (mem_req) q++;
        @(negedge clk);
        n++;
      end while (!done && n < 20);
      start_i = 1'b0;
      chk(n == 3, "R10", "held start latency", 16'(n), 16'd3);
      chk(operand == e_op, "R10", "held start operand", operand, e_op);
      d = 0;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (done) d++;
        if (mem_req) q++;
      end
      chk(d == 0, "R10", "extra done pulses", 16'(d), 16'd0);
      chk(q == 1, "R10", "requests", 16'(q), 16'd1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule